// File: doc/BRIEF.md
# Storage Controller Interrupt Aggregator

This block collects the interrupt sources of a disk-interface controller and turns them into two request lines: one to the CPU and one to a DMA engine. Its sources are an asynchronous drive interrupt, single-cycle FIFO overflow and underflow event strobes, and a level flag that is high while the protocol engine sits idle with no bus activity. Software sees three byte registers on a simple synchronous register bus: a read-only pending register, a read/write enable register and a write-one-to-clear register.

The pending bits come in two kinds. The drive-interrupt copies and the idle bit are live levels that the clear register cannot touch. The FIFO error bits are sticky and stay set until software clears them. The drive interrupt appears twice in the pending register. The copy in bit 7 feeds only the DMA end-of-transfer alarm. The copy in bit 3 feeds only the CPU interrupt. Both outputs are combinational functions of the pending and enable state, so software sees a change one clock edge after its register write.

Top module: `storage_irq_agg`

## Requirements
- R1: After reset the enable register reads 0, both sticky error bits are 0, and the CPU interrupt and DMA alarm are low.
- R2: The drive interrupt input passes through a two-flop synchronizer. A level presented before a rising edge shows in pending bits 7 and 3 after the second rising edge, and not after the first.
- R3: The DMA alarm is high exactly when pending bit 7 and enable bit 7 are both set. Enable bits 6 to 3 have no effect on it.
- R4: The CPU interrupt is the OR over bits 6, 5, 4 and 3 of pending AND enable. Bit 7 has no effect on it.
- R5: Pending bit 6 (underflow) and pending bit 5 (overflow) are set on the edge after their event strobe is sampled high. They stay set until a write to the clear register has a 1 in the same bit position.
- R6: If an error event and a clear write to the same sticky bit meet in one cycle, the bit stays set.
- R7: Writes to the clear register leave bits 7, 4 and 3 unchanged. Pending bit 4 follows the idle input level with no added latency.
- R8: The pending register is at offset 0, the enable register at offset 1 and the clear register at offset 2. The enable register keeps only bits 7 to 3, and bits 2 to 0 read as 0. Writes to offset 0 are ignored. Offset 2 and all other offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| drvIrqAsync | input | 1 | Drive interrupt level, asynchronous |
| fifoOvfEvt | input | 1 | FIFO overflow event strobe |
| fifoUdfEvt | input | 1 | FIFO underflow event strobe |
| engineIdle | input | 1 | Protocol engine idle, no bus activity |
| regAddr | input | 4 | Register byte offset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data, combinational from regAddr |
| cpuIrq | output | 1 | Interrupt request to the CPU |
| dmaXferAlarm | output | 1 | End-of-transfer alarm to the DMA engine |

## Verification
The bench runs an error event and a clear write for the same bit in one cycle. A design that let the clear win would lose that event. It writes all ones to the clear register while the drive interrupt and idle inputs are high, which exposes a design that lets the clear reach the live bits. It enables only bit 3 or only bit 7 to catch crossed routing between the two drive-interrupt copies. It also samples pending one edge and then two edges after the drive interrupt changes, which exposes a synchronizer of the wrong depth. Random traffic compares every output against a bench model on each cycle.

// File: rtl/storage_irq_pkg.sv
package storage_irq_pkg;
  localparam int DATA_W   = 8;
  localparam int BIT_DRV1 = 7;
  localparam int BIT_UDF  = 6;
  localparam int BIT_OVF  = 5;
  localparam int BIT_IDLE = 4;
  localparam int BIT_DRV2 = 3;
  localparam logic [DATA_W-1:0] IMPL_MASK = 8'hF8;
  localparam logic [DATA_W-1:0] CPU_MASK  = 8'h78;

  typedef struct packed {
    logic enWr;
    logic clrWr;
  } ctrlStrobes_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= asyncIn;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], asyncIn};
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import storage_irq_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int PEND_OFS = 0,
  parameter int EN_OFS   = 1,
  parameter int CLR_OFS  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] pendVec,
  input  logic [DATA_W-1:0] enVec,
  output ctrlStrobes_t      strb,
  output logic [DATA_W-1:0] regRdData
);
  localparam logic [ADDR_W-1:0] PendAddr = ADDR_W'(PEND_OFS);
  localparam logic [ADDR_W-1:0] EnAddr   = ADDR_W'(EN_OFS);
  localparam logic [ADDR_W-1:0] ClrAddr  = ADDR_W'(CLR_OFS);

  always_comb begin
    strb.enWr  = regWrEn && (regAddr == EnAddr);
    strb.clrWr = regWrEn && (regAddr == ClrAddr);
  end

  always_comb begin
    if (regAddr == PendAddr)    regRdData = pendVec & IMPL_MASK;
    else if (regAddr == EnAddr) regRdData = enVec & IMPL_MASK;
    else                        regRdData = '0;
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.enWr && strb.clrWr)); // R8
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import storage_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              drvIrqSync,
  input  logic              fifoOvfEvt,
  input  logic              fifoUdfEvt,
  input  logic              engineIdle,
  output logic [DATA_W-1:0] pendVec,
  output logic [DATA_W-1:0] enVec,
  output logic              cpuIrq,
  output logic              dmaXferAlarm
);
  logic ovfPend, udfPend;
  logic ovfClr, udfClr;

  assign ovfClr = strb.clrWr && wrData[BIT_OVF];
  assign udfClr = strb.clrWr && wrData[BIT_UDF];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfPend <= 1'b0;
      udfPend <= 1'b0;
    end else begin
      ovfPend <= fifoOvfEvt | (ovfPend & ~ovfClr);
      udfPend <= fifoUdfEvt | (udfPend & ~udfClr);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          enVec <= '0;
    else if (strb.enWr) enVec <= wrData & IMPL_MASK;
  end

  always_comb begin
    pendVec           = '0;
    pendVec[BIT_DRV1] = drvIrqSync;
    pendVec[BIT_UDF]  = udfPend;
    pendVec[BIT_OVF]  = ovfPend;
    pendVec[BIT_IDLE] = engineIdle;
    pendVec[BIT_DRV2] = drvIrqSync;
  end

  assign cpuIrq       = |(pendVec & enVec & CPU_MASK);
  assign dmaXferAlarm = pendVec[BIT_DRV1] & enVec[BIT_DRV1];

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ovfPend && !ovfClr) |=> ovfPend); // R5
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (fifoUdfEvt && udfClr) |=> udfPend); // R6
  AST_DMA_GATED: assert property (@(posedge clk) disable iff (!rstN)
    dmaXferAlarm |-> (enVec[BIT_DRV1] && drvIrqSync)); // R3
  AST_CPU_GATED: assert property (@(posedge clk) disable iff (!rstN)
    cpuIrq |-> (|enVec[BIT_UDF:BIT_DRV2])); // R4
  AST_LIVE_CLR: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrWr |=> (pendVec[BIT_IDLE] == engineIdle)); // R7
endmodule

// File: rtl/storage_irq_agg.sv
module storage_irq_agg
  import storage_irq_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int PEND_OFS    = 0,
  parameter int EN_OFS      = 1,
  parameter int CLR_OFS     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              drvIrqAsync,
  input  logic              fifoOvfEvt,
  input  logic              fifoUdfEvt,
  input  logic              engineIdle,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              cpuIrq,
  output logic              dmaXferAlarm
);
  ctrlStrobes_t      strb;
  logic              drvIrqSync;
  logic [DATA_W-1:0] pendVec, enVec;

  irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(drvIrqAsync), .syncOut(drvIrqSync)
  );

  irq_ctrl #(
    .ADDR_W(ADDR_W), .PEND_OFS(PEND_OFS), .EN_OFS(EN_OFS), .CLR_OFS(CLR_OFS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .pendVec(pendVec), .enVec(enVec), .strb(strb), .regRdData(regRdData)
  );

  irq_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(regWrData),
    .drvIrqSync(drvIrqSync), .fifoOvfEvt(fifoOvfEvt), .fifoUdfEvt(fifoUdfEvt),
    .engineIdle(engineIdle), .pendVec(pendVec), .enVec(enVec),
    .cpuIrq(cpuIrq), .dmaXferAlarm(dmaXferAlarm)
  );
endmodule

// File: tb/test_storage_irq_agg.sv
module test_storage_irq_agg;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       drvIrqAsync = 1'b0, fifoOvfEvt = 1'b0, fifoUdfEvt = 1'b0, engineIdle = 1'b0;
  logic [3:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       cpuIrq, dmaXferAlarm;

  int  testCount = 0, failCount = 0;
  bit  finished = 0;

  // bench model state
  logic s1 = 0, s2 = 0, mOvf = 0, mUdf = 0;
  logic [7:0] mEn = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  storage_irq_agg i_storage_irq_agg (
    .clk(clk), .rstN(rstN), .drvIrqAsync(drvIrqAsync), .fifoOvfEvt(fifoOvfEvt),
    .fifoUdfEvt(fifoUdfEvt), .engineIdle(engineIdle), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .cpuIrq(cpuIrq), .dmaXferAlarm(dmaXferAlarm)
  );

  function automatic logic [7:0] expPend();
    return {s2, mUdf, mOvf, engineIdle, s2, 3'b000};
  endfunction

  function automatic logic [7:0] expRd();
    if (regAddr == 4'd0) return expPend();
    if (regAddr == 4'd1) return mEn;
    return 8'h00;
  endfunction

  function automatic logic expCpu();
    return |(expPend() & mEn & 8'h78);
  endfunction

  function automatic logic expDma();
    return expPend()[7] & mEn[7];
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // model update for the rising edge about to happen, using the driven inputs
  task automatic modelEdge();
    logic clrW;
    clrW = regWrEn && regAddr == 4'd2;
    s2 = s1; s1 = drvIrqAsync;
    mOvf = fifoOvfEvt | (mOvf & ~(clrW & regWrData[5]));
    mUdf = fifoUdfEvt | (mUdf & ~(clrW & regWrData[6]));
    if (regWrEn && regAddr == 4'd1) mEn = regWrData & 8'hF8;
  endtask

  // inputs are already driven (at negedge); run one edge, then check at negedge
  task automatic cycle(string rdTag);
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    check(rdTag, regRdData, expRd());
    check("R4 cpuIrq", {7'd0, cpuIrq}, {7'd0, expCpu()});
    check("R3 dmaXferAlarm", {7'd0, dmaXferAlarm}, {7'd0, expDma()});
  endtask

  task automatic drive(logic drv, logic ovf, logic udf, logic idle,
                       logic [3:0] a, logic we, logic [7:0] wd);
    drvIrqAsync = drv; fifoOvfEvt = ovf; fifoUdfEvt = udf; engineIdle = idle;
    regAddr = a; regWrEn = we; regWrData = wd;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    // R1 reset state, enable register at offset 1
    regAddr = 4'd1;
    #1;
    check("R1 enable after reset", regRdData, 8'h00);
    check("R1 cpuIrq after reset", {7'd0, cpuIrq}, 8'h00);
    check("R1 dmaXferAlarm after reset", {7'd0, dmaXferAlarm}, 8'h00);
    @(negedge clk); rstN = 1'b1;
    drive(0, 0, 0, 0, 4'd0, 0, 8'h00);
    cycle("R1 pending after reset");

    // R2 synchronizer latency
    drive(1, 0, 0, 0, 4'd0, 0, 8'h00);
    cycle("R2 pending one edge");
    check("R2 not yet after one edge", regRdData, 8'h00);
    cycle("R2 pending two edges");
    check("R2 bits 7 and 3 after two edges", regRdData, 8'h88);

    // R3 only bit 3 enabled: cpu yes, dma no
    drive(1, 0, 0, 0, 4'd1, 1, 8'h08);
    cycle("R8 enable write");
    regWrEn = 0;
    cycle("R8 enable readback");
    check("R3 dma low with only bit 3 enabled", {7'd0, dmaXferAlarm}, 8'h00);
    check("R4 cpu high from bit 3", {7'd0, cpuIrq}, 8'h01);
    // only bit 7 enabled: dma yes, cpu no
    drive(1, 0, 0, 0, 4'd1, 1, 8'hFF);
    cycle("R8 enable keeps 7..3");
    check("R8 enable low bits read 0", regRdData, 8'hF8);
    drive(1, 0, 0, 0, 4'd1, 1, 8'h80);
    cycle("R8 enable write 80");
    check("R3 dma high from bit 7", {7'd0, dmaXferAlarm}, 8'h01);
    check("R4 cpu ignores bit 7", {7'd0, cpuIrq}, 8'h00);

    // R7 clear all ones does not touch live bits
    drive(1, 0, 0, 1, 4'd2, 1, 8'hFF);
    cycle("R8 clear reads 0");
    check("R8 clear offset reads 0", regRdData, 8'h00);
    regWrEn = 0; regAddr = 4'd0;
    cycle("R7 pending after clear");
    check("R7 live bits survive clear", regRdData, 8'h98);

    // R5 sticky set and hold, R6 event wins
    drive(0, 1, 1, 0, 4'd0, 0, 8'h00);
    cycle("R5 sticky set");
    drive(0, 0, 0, 0, 4'd0, 1, 8'hFF);
    cycle("R8 write to pending ignored");
    check("R5 sticky held, pending write ignored", regRdData, 8'h60);
    drive(0, 1, 0, 0, 4'd2, 1, 8'h60);
    cycle("R6 event vs clear");
    regWrEn = 0; fifoOvfEvt = 0; regAddr = 4'd0;
    cycle("R6 readback");
    check("R6 overflow survives same-cycle clear", regRdData, 8'h20);
    drive(0, 0, 0, 0, 4'd2, 1, 8'h20);
    cycle("R5 clear overflow");
    regWrEn = 0; regAddr = 4'd0;
    cycle("R5 readback");
    check("R5 overflow cleared", regRdData, 8'h00);
    regAddr = 4'd9;
    cycle("R8 unmapped offset reads 0");

    // constrained random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] a;
      a = ($urandom % 8 == 0) ? 4'($urandom) : 4'($urandom % 3);
      drive(($urandom % 4) != 0 ? drvIrqAsync : ~drvIrqAsync,
            ($urandom % 8) == 0, ($urandom % 8) == 0, $urandom % 2,
            a, ($urandom % 3) == 0, 8'($urandom));
      cycle("R8 random readback");
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule